// File: doc/BRIEF.md
# Debug Breakpoint Qualification Filter

This block sits between the raw comparator strobes of a processor's on-chip debug logic and the core's breakpoint exception request. It decides which raw instruction matches, load/store matches and counter-generated breakpoint strobes become a qualified internal breakpoint request. It also produces the watchpoint pulses sent to external pins and the enable pulses for the debug event counters.

The decision depends on the machine state's recoverable-interrupt bit. In the default maskable mode, breakpoints and counter enables are discarded while that bit is clear. In nonmaskable mode breakpoints always fire, and firing while the bit is clear raises a sticky nonrestartable-state flag. A self-clearing skip-first bit lets a debugger resume from a breakpointed instruction without hitting it again. That bit applies only to direct instruction matches.

All outputs are registered, so each appears one clock after the strobes that cause it. Software reaches the mode bit, the skip-first bit and the flag clear through single-cycle write strobes.

Top module: `brk_qual_filter`

## Requirements
- R1: In maskable mode, with the recoverable bit at 0, no breakpoint request is raised. A breakpoint dropped this way is never raised in a later cycle.
- R2: In maskable mode, with the recoverable bit at 0, all counter-enable outputs stay 0. In every other case each counter-enable bit follows its match bit one cycle later.
- R3: The watchpoint outputs equal the raw instruction and load/store match vectors of the previous cycle, whatever the mode, the recoverable bit and the skip-first bit.
- R4: In nonmaskable mode a breakpoint is raised whatever the recoverable bit is. A breakpoint raised while that bit is 0 sets a sticky nonrestartable flag. The flag is cleared only by reset or by the software clear strobe, and setting wins over a clear in the same cycle.
- R5: Reset selects maskable mode. A mode write (value 1 = nonmaskable, 0 = maskable) applies from the next cycle, and that one bit governs instruction, load/store and counter-generated breakpoints alike.
- R6: With the skip-first bit at 1, the first instruction match that passes the context gate raises no breakpoint, and the bit reads 0 from the next cycle. A match dropped by the context gate leaves the bit set.
- R7: With the skip-first bit at 0, every instruction match that passes the context gate raises a breakpoint.
- R8: Load/store matches and counter-generated breakpoints raise a breakpoint regardless of the skip-first bit and never clear it. When a suppressed instruction match coincides with one of them, a breakpoint is still raised.
- R9: A software write of the skip-first bit in the same cycle as its hardware clear takes effect, so the written value wins.
- R10: The breakpoint request is registered one clock after its triggering strobe and lasts a single cycle unless another qualified strobe follows.
- R11: An instruction match suppressed by the skip-first bit still appears on the watchpoint outputs and still drives its counter enable.
- R12: During and just after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_match_i | input | NUM_IWP | Raw instruction comparator strobes |
| ls_match_i | input | NUM_LWP | Raw load/store comparator strobes |
| cnt_insn_brk_i | input | 1 | Counter-generated instruction breakpoint strobe |
| cnt_ls_brk_i | input | 1 | Counter-generated load/store breakpoint strobe |
| msr_ri_i | input | 1 | Recoverable-interrupt bit of the machine state |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_nomask_i | input | 1 | Mode write value, 1 = nonmaskable |
| ifm_wr_i | input | 1 | Skip-first bit write strobe |
| ifm_val_i | input | 1 | Skip-first bit write value |
| nrs_clr_i | input | 1 | Software clear of the nonrestartable flag |
| brk_req_o | output | 1 | Qualified internal breakpoint request pulse |
| wp_insn_o | output | NUM_IWP | Instruction watchpoint pulses to pins |
| wp_ls_o | output | NUM_LWP | Load/store watchpoint pulses to pins |
| cnt_en_insn_o | output | NUM_IWP | Counter enables for instruction watchpoints |
| cnt_en_ls_o | output | NUM_LWP | Counter enables for load/store watchpoints |
| nonrestart_o | output | 1 | Sticky nonrestartable-state flag |
| ifm_o | output | 1 | Current skip-first bit |

## Verification
Two functions can land in the same cycle. The hardware clear of the skip-first bit can meet a software write of that bit. The setting of the nonrestartable flag can meet its software clear. The vector table provokes both on purpose: it drives a skip-first write together with the instruction match that consumes the bit, and a clear strobe together with an unrecoverable counter breakpoint in nonmaskable mode. In each case the written bit and the flag are read back one cycle later and must hold the value the winning side dictates. A further row drives a suppressed instruction match together with a load/store match, to confirm that the skip-first bit is spent while the breakpoint still fires.

// File: rtl/brk_qual_pkg.sv
package brk_qual_pkg;

    typedef enum logic {
        MODE_MASKABLE = 1'b0,
        MODE_NONMASK  = 1'b1
    } brk_mode_e;

endpackage

// File: rtl/brk_ctx_gate.sv
module brk_ctx_gate
    import brk_qual_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      mode_wr_i,
    input  logic      mode_nomask_i,
    input  logic      msr_ri_i,
    output brk_mode_e mode_o,
    output logic      gate_open_o
);

    typedef struct packed {
        brk_mode_e mode;
    } gate_state_t;

    gate_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (mode_wr_i) begin
            state_d.mode = mode_nomask_i ? MODE_NONMASK : MODE_MASKABLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{mode: MODE_MASKABLE};
        end else begin
            state_q <= state_d;
        end
    end

    assign mode_o      = state_q.mode;
    assign gate_open_o = (state_q.mode == MODE_NONMASK) || msr_ri_i;

    // R5: a mode write is visible in the following cycle
    p_mode_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_wr_i |=> (mode_o == (($past(mode_nomask_i)) ? MODE_NONMASK : MODE_MASKABLE)));

    // R5: mode holds when not written
    p_mode_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_wr_i |=> $stable(mode_o));

endmodule

// File: rtl/brk_ifm_ctl.sv
module brk_ifm_ctl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_i,
    input  logic val_i,
    input  logic insn_hit_i,
    input  logic gate_open_i,
    output logic ifm_o,
    output logic suppress_o
);

    typedef struct packed {
        logic skip;
    } ifm_state_t;

    ifm_state_t state_d, state_q;
    logic       consume;

    always_comb begin
        consume = state_q.skip && insn_hit_i && gate_open_i;
        state_d = state_q;
        if (consume) begin
            state_d.skip = 1'b0;
        end
        if (wr_i) begin
            state_d.skip = val_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{skip: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign ifm_o      = state_q.skip;
    assign suppress_o = consume;

    // R6: a qualified instruction match spends the skip-first bit
    p_ifm_consume_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ifm_o && insn_hit_i && gate_open_i && !wr_i) |=> !ifm_o);

    // R9: a software write always lands
    p_ifm_swwin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (ifm_o == $past(val_i)));

    // R8: without an instruction match or a write the bit is unchanged
    p_ifm_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_i && !insn_hit_i) |=> $stable(ifm_o));

endmodule

// File: rtl/brk_nrs_flag.sv
module brk_nrs_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } nrs_state_t;

    nrs_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d.flag = 1'b0;
        end
        if (set_i) begin
            state_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{flag: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_o = state_q.flag;

    // R4: the flag is sticky until cleared
    p_nrs_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !clr_i) |=> flag_o);

    // R4: setting wins over a simultaneous clear
    p_nrs_setwin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> flag_o);

endmodule

// File: rtl/brk_qual_filter.sv
module brk_qual_filter
    import brk_qual_pkg::*;
#(
    parameter int NUM_IWP = 4,
    parameter int NUM_LWP = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IWP-1:0] insn_match_i,
    input  logic [NUM_LWP-1:0] ls_match_i,
    input  logic               cnt_insn_brk_i,
    input  logic               cnt_ls_brk_i,
    input  logic               msr_ri_i,
    input  logic               mode_wr_i,
    input  logic               mode_nomask_i,
    input  logic               ifm_wr_i,
    input  logic               ifm_val_i,
    input  logic               nrs_clr_i,
    output logic               brk_req_o,
    output logic [NUM_IWP-1:0] wp_insn_o,
    output logic [NUM_LWP-1:0] wp_ls_o,
    output logic [NUM_IWP-1:0] cnt_en_insn_o,
    output logic [NUM_LWP-1:0] cnt_en_ls_o,
    output logic               nonrestart_o,
    output logic               ifm_o
);

    localparam int OUT_W = 1 + 2 * NUM_IWP + 2 * NUM_LWP;

    typedef struct packed {
        logic               brk;
        logic [NUM_IWP-1:0] wp_i;
        logic [NUM_LWP-1:0] wp_l;
        logic [NUM_IWP-1:0] ce_i;
        logic [NUM_LWP-1:0] ce_l;
    } out_regs_t;

    out_regs_t out_d, out_q;

    brk_mode_e mode_w;
    logic      gate_open_w;
    logic      suppress_w;
    logic      insn_hit_w;
    logic      ls_hit_w;
    logic      cnt_hit_w;
    logic      nrs_set_w;

    brk_ctx_gate u_gate (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .mode_wr_i     (mode_wr_i),
        .mode_nomask_i (mode_nomask_i),
        .msr_ri_i      (msr_ri_i),
        .mode_o        (mode_w),
        .gate_open_o   (gate_open_w)
    );

    brk_ifm_ctl u_ifm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (ifm_wr_i),
        .val_i       (ifm_val_i),
        .insn_hit_i  (insn_hit_w),
        .gate_open_i (gate_open_w),
        .ifm_o       (ifm_o),
        .suppress_o  (suppress_w)
    );

    brk_nrs_flag u_nrs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (nrs_set_w),
        .clr_i  (nrs_clr_i),
        .flag_o (nonrestart_o)
    );

    always_comb begin
        insn_hit_w = |insn_match_i;
        ls_hit_w   = |ls_match_i;
        cnt_hit_w  = cnt_insn_brk_i || cnt_ls_brk_i;

        out_d.wp_i = insn_match_i;
        out_d.wp_l = ls_match_i;

        for (int i = 0; i < NUM_IWP; i++) begin
            out_d.ce_i[i] = insn_match_i[i] && gate_open_w;
        end
        for (int j = 0; j < NUM_LWP; j++) begin
            out_d.ce_l[j] = ls_match_i[j] && gate_open_w;
        end

        out_d.brk = gate_open_w &&
                    ((insn_hit_w && !suppress_w) || ls_hit_w || cnt_hit_w);

        nrs_set_w = out_d.brk && !msr_ri_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= out_regs_t'({OUT_W{1'b0}});
        end else begin
            out_q <= out_d;
        end
    end

    assign brk_req_o     = out_q.brk;
    assign wp_insn_o     = out_q.wp_i;
    assign wp_ls_o       = out_q.wp_l;
    assign cnt_en_insn_o = out_q.ce_i;
    assign cnt_en_ls_o   = out_q.ce_l;

    // R1: nothing is raised from an unrecoverable cycle in maskable mode
    p_mask_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_w == MODE_MASKABLE && !msr_ri_i) |=> !brk_req_o);

    // R2: counters are not advanced from an unrecoverable cycle in maskable mode
    p_mask_cnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_w == MODE_MASKABLE && !msr_ri_i) |=>
            (cnt_en_insn_o == '0 && cnt_en_ls_o == '0));

    // R3: watchpoint pins mirror raw strobes one cycle later
    p_wp_fwd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (wp_insn_o == $past(insn_match_i) && wp_ls_o == $past(ls_match_i)));

    // R4: a request from an unrecoverable cycle leaves the flag set
    p_nrs_on_unrec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (brk_req_o && !$past(msr_ri_i)) |-> nonrestart_o);

    // R10: no request without a strobe in the previous cycle
    p_req_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_match_i == '0 && ls_match_i == '0 && !cnt_insn_brk_i && !cnt_ls_brk_i)
            |=> !brk_req_o);

    // R11: a suppressed match still reaches the watchpoint pins
    p_supp_wp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        suppress_w |=> (wp_insn_o != '0));

endmodule

// File: tb/tb_brk_qual_filter.sv
module tb_brk_qual_filter;

    localparam int NI = 2;
    localparam int NL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] insn_match = '0;
    logic [NL-1:0] ls_match = '0;
    logic          cnt_ib = 1'b0;
    logic          cnt_lb = 1'b0;
    logic          ri = 1'b0;
    logic          mode_wr = 1'b0;
    logic          mode_val = 1'b0;
    logic          ifm_wr = 1'b0;
    logic          ifm_val = 1'b0;
    logic          nrs_clr = 1'b0;
    logic          brk_req;
    logic [NI-1:0] wp_insn;
    logic [NL-1:0] wp_ls;
    logic [NI-1:0] ce_insn;
    logic [NL-1:0] ce_ls;
    logic          nrs;
    logic          ifm;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    brk_qual_filter #(.NUM_IWP(NI), .NUM_LWP(NL)) dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .insn_match_i  (insn_match),
        .ls_match_i    (ls_match),
        .cnt_insn_brk_i(cnt_ib),
        .cnt_ls_brk_i  (cnt_lb),
        .msr_ri_i      (ri),
        .mode_wr_i     (mode_wr),
        .mode_nomask_i (mode_val),
        .ifm_wr_i      (ifm_wr),
        .ifm_val_i     (ifm_val),
        .nrs_clr_i     (nrs_clr),
        .brk_req_o     (brk_req),
        .wp_insn_o     (wp_insn),
        .wp_ls_o       (wp_ls),
        .cnt_en_insn_o (ce_insn),
        .cnt_en_ls_o   (ce_ls),
        .nonrestart_o  (nrs),
        .ifm_o         (ifm)
    );

    typedef struct packed {
        logic       mw, mv, fw, fv, nc, r;
        logic [1:0] im, lm;
        logic       ci, cl;
        logic       e_brk, e_nrs, e_ifm;
        logic [1:0] e_ci, e_cl;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        //   mw mv fw fv nc ri  im     lm    ci cl  brk nrs ifm eci   ecl
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,2'b00,1'b0,1'b0, 1'b1,1'b0,1'b0,2'b01,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,2'b00,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b01,1'b0,1'b1, 1'b0,1'b0,1'b0,2'b00,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b11,1'b0,1'b0, 1'b1,1'b0,1'b0,2'b00,2'b11},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,1'b0,1'b0, 1'b1,1'b1,1'b0,2'b01,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,1'b0, 1'b0,1'b1,1'b0,2'b00,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'b00,2'b00,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b00,2'b00,1'b1,1'b0, 1'b1,1'b1,1'b0,2'b00,2'b00},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,2'b00,2'b00,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,2'b00},
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,2'b00,2'b00,1'b0,1'b0, 1'b0,1'b0,1'b1,2'b00,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b10,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00,1'b0,1'b0, 1'b1,1'b0,1'b0,2'b10,2'b00},
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,2'b00,2'b00,1'b0,1'b0, 1'b0,1'b0,1'b1,2'b00,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b01,1'b0,1'b0, 1'b1,1'b0,1'b1,2'b00,2'b01},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b00,1'b1,1'b0, 1'b1,1'b0,1'b1,2'b00,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,1'b0,1'b0, 1'b0,1'b0,1'b1,2'b00,2'b00},
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,2'b01,2'b00,1'b0,1'b0, 1'b0,1'b0,1'b1,2'b01,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,2'b01,1'b0,1'b0, 1'b1,1'b0,1'b0,2'b01,2'b01},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,1'b1, 1'b1,1'b0,1'b0,2'b00,2'b00},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,2'b00}
    };

    function automatic string row_tag(int k);
        case (k)
            0:           return "R7";
            1, 2:        return "R1";
            3:           return "R2";
            4:           return "R10";
            5:           return "R5";
            6, 7, 8, 9, 10: return "R4";
            11, 14, 18:  return "R9";
            12:          return "R11";
            13, 17:      return "R6";
            15, 16, 19:  return "R8";
            default:     return "R10";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        mode_wr    = v.mw;
        mode_val   = v.mv;
        ifm_wr     = v.fw;
        ifm_val    = v.fv;
        nrs_clr    = v.nc;
        ri         = v.r;
        insn_match = v.im;
        ls_match   = v.lm;
        cnt_ib     = v.ci;
        cnt_lb     = v.cl;
    endtask

    task automatic idle_inputs();
        drive('0);
    endtask

    task automatic all_zero(string tag);
        chk(tag, "brk", {7'd0, brk_req}, 8'd0);
        chk(tag, "nrs", {7'd0, nrs}, 8'd0);
        chk(tag, "ifm", {7'd0, ifm}, 8'd0);
        chk(tag, "wp", {4'd0, wp_insn, wp_ls}, 8'd0);
        chk(tag, "cnt_en", {4'd0, ce_insn, ce_ls}, 8'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        vec_t v;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R12: outputs held at zero during reset
        all_zero("R12");
        rst_n = 1'b1;
        @(negedge clk);
        all_zero("R12");

        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            drive(v);
            @(posedge clk);
            @(negedge clk);
            chk(row_tag(k), "brk", {7'd0, brk_req}, {7'd0, v.e_brk});
            chk(row_tag(k), "nrs", {7'd0, nrs}, {7'd0, v.e_nrs});
            chk(row_tag(k), "ifm", {7'd0, ifm}, {7'd0, v.e_ifm});
            chk("R3", "wp_insn", {6'd0, wp_insn}, {6'd0, v.im});
            chk("R3", "wp_ls", {6'd0, wp_ls}, {6'd0, v.lm});
            chk("R2", "cnt_insn", {6'd0, ce_insn}, {6'd0, v.e_ci});
            chk("R2", "cnt_ls", {6'd0, ce_ls}, {6'd0, v.e_cl});
        end

        // Directed: set nonmaskable mode and skip-first, then reset mid-run
        v = '0;
        v.mw = 1'b1; v.mv = 1'b1; v.fw = 1'b1; v.fv = 1'b1; v.r = 1'b1;
        drive(v);
        @(posedge clk);
        @(negedge clk);
        chk("R9", "ifm before reset", {7'd0, ifm}, 8'd1);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        all_zero("R12");
        rst_n = 1'b1;
        @(negedge clk);
        all_zero("R12");

        // R5: after reset the mode is maskable again
        v = '0;
        v.im = 2'b01;
        drive(v);
        @(posedge clk);
        @(negedge clk);
        chk("R5", "brk after reset", {7'd0, brk_req}, 8'd0);
        chk("R5", "nrs after reset", {7'd0, nrs}, 8'd0);
        chk("R5", "cnt after reset", {6'd0, ce_insn}, 8'd0);

        // R10: back-to-back qualified strobes then idle
        v = '0;
        v.r = 1'b1; v.lm = 2'b10;
        drive(v);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "brk first", {7'd0, brk_req}, 8'd1);
        drive(v);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "brk second", {7'd0, brk_req}, 8'd1);
        idle_inputs();
        @(posedge clk);
        @(negedge clk);
        chk("R10", "brk drop", {7'd0, brk_req}, 8'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule